// File: doc/BRIEF.md
# Ring Oscillator Race Response Generator

This block turns a challenge word into a device-specific response. It uses the small frequency differences between nominally identical ring oscillators. A bank of oscillator signals is shared by two selection trees. The low and high halves of the challenge each pick one oscillator. Each picked oscillator clocks a small wrap-around counter of its own. Whichever counter wraps first wins the race, and the winner sets one response bit.

A full response takes several races. Each start request runs one race per response bit. Race k uses the challenge rotated left by k places, so every response bit compares a different pair of oscillators.

Two clocks pace the work:
- The slow load clock opens a new race on each rising edge, reloading both oscillator selections and restarting the counters.
- The fast capture clock receives the wrap events through two-flop synchronizers, decides each race, collects the bits and raises a one-cycle done flag.

Reset is synchronous and active-low, and every clock domain samples it. The caller must hold it long enough for each domain to see at least one edge.

Top module: `ro_race_puf`

## Requirements
- R1: Challenge bits [3:0] select the oscillator of lane A and bits [7:4] select the oscillator of lane B. A race bit is 1 when lane A's counter wraps first and 0 when lane B's counter wraps first.
- R2: Both lanes select from the same bank of N_OSC oscillator inputs. Every index 0..N_OSC-1 is reachable from either challenge field through a two-level tree: 4-way leaf multiplexers followed by a group selector.
- R3: Each lane counter is CNT_W bits wide and counts rising edges of its oscillator from zero at the start of a race. Only its first wrap from all ones to zero in a race is reported, and later wraps in the same race do not change the decided bit.
- R4: Race k (k = 0..RESP_W-1) uses the challenge rotated left by k bit places, and its result is placed in response bit k.
- R5: When both wrap events reach the capture domain in the same capture-clock cycle, the race bit is TIE_BIT. This always happens when both challenge fields are equal.
- R6: When neither counter wraps before the next load-clock edge, the race bit is TIE_BIT.
- R7: A sequence uses exactly RESP_W+1 load-clock rising edges: the start edge, RESP_W-1 reloads and one closing edge. After the closing edge, done is high for exactly one capture-clock cycle, and response takes its new value in that same cycle. Response holds that value until the next done.
- R8: A start request that arrives while a sequence is running is ignored, and the running sequence completes with its original challenge.
- R9: After reset, response is all zeros and done is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_bank | input | N_OSC | Free-running oscillator signals, one per source |
| outer_clk | input | 1 | Load clock; each rising edge opens a new race |
| inner_clk | input | 1 | Capture clock for synchronizers, race decision and output |
| rst_n | input | 1 | Synchronous active-low reset, sampled in every domain |
| challenge | input | 2*log2(N_OSC) | Challenge word, sampled at the load edge that accepts start |
| start | input | 1 | Start request, sampled on outer_clk |
| response | output | RESP_W | Collected race bits, bit k from race k |
| done | output | 1 | One capture-cycle pulse when a new response is presented |

## Verification
The bench builds the block with N_OSC=16, RESP_W=8, CNT_W=8 and TIE_BIT=1, and it gives every oscillator its own period, each inside ±5% of 40 ns. The 8-bit counters stretch a race to about 258 oscillator periods. That lets a single step of about 0.27 ns between neighbouring periods outgrow both the start jitter and the capture-clock quantization, so every race between distinct oscillators has a predictable winner. Setting TIE_BIT to 1 keeps tied and timed-out races apart from lane-B wins. The bench varies the load-clock period to cover three cases: windows too short for any wrap, the nominal window, and windows long enough for counters to wrap more than once.

// File: rtl/ro_puf_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the oscillator race response generator.
// Assumes: the leaf width of the selection tree is a power of two.
package ro_puf_pkg;

    // Width of the leaf multiplexers in each oscillator selection tree
    localparam int unsigned MUX_LEAF_WAYS = 4;

    // Outcome of one race as seen in the capture domain
    typedef enum logic [1:0] {
        VERD_NONE = 2'd0,
        VERD_A    = 2'd1,
        VERD_B    = 2'd2,
        VERD_TIE  = 2'd3
    } verdict_e;

    // Map a race outcome to the response bit it contributes
    function automatic logic verdict_bit(input verdict_e v, input bit tie_bit);
        case (v)
            VERD_A:  return 1'b1;
            VERD_B:  return 1'b0;
            default: return tie_bit;
        endcase
    endfunction

endpackage

// File: rtl/ro_select_tree.sv
`timescale 1ns/1ps
// Oscillator selection tree: picks one of N_OSC oscillator signals.
// Built from N_OSC/LEAF_WAYS leaf multiplexers plus one group selector.
// Assumes: N_OSC is a power of two and larger than LEAF_WAYS.
module ro_select_tree #(
    parameter int unsigned N_OSC     = 16,
    parameter int unsigned LEAF_WAYS = ro_puf_pkg::MUX_LEAF_WAYS,
    parameter int unsigned SEL_W     = $clog2(N_OSC)
) (
    input  logic [N_OSC-1:0] osc_bank,
    input  logic [SEL_W-1:0] sel,
    output logic             clk_out
);
    localparam int unsigned LEAF_SEL_W = $clog2(LEAF_WAYS);
    localparam int unsigned GROUPS     = N_OSC / LEAF_WAYS;

    logic [GROUPS-1:0]     leaf_out;
    logic [LEAF_SEL_W-1:0] sel_lo;
    logic [SEL_W-LEAF_SEL_W-1:0] sel_hi;

    assign sel_lo = sel[LEAF_SEL_W-1:0];
    assign sel_hi = sel[SEL_W-1:LEAF_SEL_W];

    // One leaf multiplexer per group of LEAF_WAYS oscillators
    for (genvar g = 0; g < GROUPS; g++) begin : g_leaf
        logic [LEAF_WAYS-1:0] grp;
        assign grp         = osc_bank[g*LEAF_WAYS +: LEAF_WAYS];
        assign leaf_out[g] = grp[sel_lo];
    end

    // Final stage chooses among the leaf outputs
    assign clk_out = leaf_out[sel_hi];

endmodule

// File: rtl/race_lane.sv
`timescale 1ns/1ps
// Race lane: a CNT_W-bit counter clocked by the selected oscillator.
// A change of the race epoch (from the load domain) is synchronized by
// two flops, then clears the counter and arms it. The first wrap after
// arming flips ovf_toggle; later wraps are not reported.
// Assumes: lane_clk keeps running while rst_n is low.
module race_lane #(
    parameter int unsigned CNT_W = 4
) (
    input  logic lane_clk,
    input  logic rst_n,
    input  logic epoch,
    output logic ovf_toggle
);
    logic [2:0]       ep_s;
    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             new_race;

    assign new_race = ep_s[1] ^ ep_s[2];

    // Synchronize the epoch, restart on a new race, report the first wrap
    always_ff @(posedge lane_clk) begin
        if (!rst_n) begin
            ep_s       <= '0;
            cnt_q      <= '0;
            armed_q    <= 1'b0;
            ovf_toggle <= 1'b0;
        end else begin
            ep_s <= {ep_s[1:0], epoch};
            if (new_race) begin
                cnt_q   <= '0;
                armed_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (armed_q && (&cnt_q)) begin
                    ovf_toggle <= ~ovf_toggle;
                    armed_q    <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/race_sequencer.sv
`timescale 1ns/1ps
// Race sequencer in the load-clock domain. A start request latches the
// challenge and opens race 0. Each later rising edge opens race k with
// the challenge rotated left by k. One closing edge follows the last
// race. Every opening or closing edge flips the epoch.
// Assumes: start and challenge are stable around outer_clk rising edges.
module race_sequencer #(
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned RESP_W = 8
) (
    input  logic               outer_clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2*SEL_W-1:0] challenge,
    output logic [SEL_W-1:0]   sel_a,
    output logic [SEL_W-1:0]   sel_b,
    output logic               epoch
);
    localparam int unsigned CH_W = 2 * SEL_W;
    localparam int unsigned K_W  = $clog2(RESP_W + 1);

    logic [CH_W-1:0] chal_q;
    logic [CH_W-1:0] rot;
    logic [K_W-1:0]  k_q;
    logic            active_q;

    // Rotate a challenge word left by k places (k taken modulo CH_W)
    function automatic logic [CH_W-1:0] rotl(input logic [CH_W-1:0] v, input int unsigned k);
        logic [CH_W-1:0] r;
        for (int unsigned i = 0; i < CH_W; i++) begin
            r[(i + k) % CH_W] = v[i];
        end
        return r;
    endfunction

    // Challenge view for the race about to be opened
    always_comb rot = rotl(chal_q, int'(k_q));

    // Open, advance and close the sequence of races
    always_ff @(posedge outer_clk) begin
        if (!rst_n) begin
            chal_q   <= '0;
            sel_a    <= '0;
            sel_b    <= '0;
            epoch    <= 1'b0;
            k_q      <= '0;
            active_q <= 1'b0;
        end else if (!active_q) begin
            if (start) begin
                chal_q   <= challenge;
                sel_a    <= challenge[SEL_W-1:0];
                sel_b    <= challenge[CH_W-1:SEL_W];
                epoch    <= ~epoch;
                k_q      <= K_W'(1);
                active_q <= 1'b1;
            end
        end else if (k_q == K_W'(RESP_W)) begin
            epoch    <= ~epoch;
            k_q      <= '0;
            active_q <= 1'b0;
        end else begin
            sel_a <= rot[SEL_W-1:0];
            sel_b <= rot[CH_W-1:SEL_W];
            epoch <= ~epoch;
            k_q   <= k_q + 1'b1;
        end
    end

endmodule

// File: rtl/race_judge.sv
`timescale 1ns/1ps
// Race judge in the capture-clock domain. It synchronizes the epoch and
// both lane wrap toggles through two flops and decides each race from the
// first wrap event (a simultaneous pair gives TIE_BIT). On each epoch
// change it commits the open race's bit into response bit k. After
// RESP_W commits it presents the response and pulses done.
// Assumes: RESP_W >= 2; a race's wrap events settle before the next epoch.
module race_judge #(
    parameter int unsigned RESP_W  = 8,
    parameter bit          TIE_BIT = 1'b0
) (
    input  logic              inner_clk,
    input  logic              rst_n,
    input  logic              epoch,
    input  logic              ovf_a,
    input  logic              ovf_b,
    output logic [RESP_W-1:0] response,
    output logic              done
);
    import ro_puf_pkg::*;

    localparam int unsigned IDX_W = $clog2(RESP_W);

    logic [2:0]        ep_s, a_s, b_s;
    logic              ev_epoch, ev_a, ev_b;
    logic              open_q;
    verdict_e          verd_q;
    logic [IDX_W-1:0]  idx_q;
    logic [RESP_W-1:0] col_q, col_n;
    logic              commit_bit;

    assign ev_epoch = ep_s[1] ^ ep_s[2];
    assign ev_a     = a_s[1] ^ a_s[2];
    assign ev_b     = b_s[1] ^ b_s[2];

    // Bit of the open race and the collection after committing it
    always_comb begin
        commit_bit = verdict_bit(verd_q, TIE_BIT);
        col_n      = {commit_bit, col_q[RESP_W-1:1]};
    end

    // Two-flop synchronizers plus one edge-detect stage per crossing
    always_ff @(posedge inner_clk) begin
        if (!rst_n) begin
            ep_s <= '0;
            a_s  <= '0;
            b_s  <= '0;
        end else begin
            ep_s <= {ep_s[1:0], epoch};
            a_s  <= {a_s[1:0], ovf_a};
            b_s  <= {b_s[1:0], ovf_b};
        end
    end

    // Decide races, collect bits, present the response with a done pulse
    always_ff @(posedge inner_clk) begin
        if (!rst_n) begin
            open_q   <= 1'b0;
            verd_q   <= VERD_NONE;
            idx_q    <= '0;
            col_q    <= '0;
            response <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (ev_epoch) begin
                verd_q <= VERD_NONE;
                if (open_q) begin
                    col_q <= col_n;
                    if (idx_q == IDX_W'(RESP_W - 1)) begin
                        response <= col_n;
                        done     <= 1'b1;
                        idx_q    <= '0;
                        open_q   <= 1'b0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end else begin
                    open_q <= 1'b1;
                    idx_q  <= '0;
                end
            end else if (open_q && (verd_q == VERD_NONE) && (ev_a || ev_b)) begin
                if (ev_a && ev_b) verd_q <= VERD_TIE;
                else if (ev_a)    verd_q <= VERD_A;
                else              verd_q <= VERD_B;
            end
        end
    end

endmodule

// File: rtl/ro_race_puf.sv
`timescale 1ns/1ps
// Ring oscillator race response generator, top level.
// Two selection trees share one oscillator bank; each drives a race lane.
// A load-clock sequencer opens one race per response bit with a rotated
// challenge, and a capture-clock judge turns first-wrap events into bits.
// Assumes: the load period covers a full race of the slowest oscillator.
module ro_race_puf #(
    parameter int unsigned N_OSC   = 16,
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned RESP_W  = 8,
    parameter bit          TIE_BIT = 1'b0
) (
    input  logic [N_OSC-1:0]             osc_bank,
    input  logic                         outer_clk,
    input  logic                         inner_clk,
    input  logic                         rst_n,
    input  logic [2*$clog2(N_OSC)-1:0]   challenge,
    input  logic                         start,
    output logic [RESP_W-1:0]            response,
    output logic                         done
);
    localparam int unsigned SEL_W = $clog2(N_OSC);

    logic [SEL_W-1:0] sel_a, sel_b;
    logic             seq_epoch;
    logic [SEL_W-1:0] lane_sel [2];
    logic [1:0]       lane_clk;
    logic [1:0]       lane_ovf;

    assign lane_sel[0] = sel_a;
    assign lane_sel[1] = sel_b;

    race_sequencer #(.SEL_W(SEL_W), .RESP_W(RESP_W)) u_seq (
        .outer_clk (outer_clk),
        .rst_n     (rst_n),
        .start     (start),
        .challenge (challenge),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .epoch     (seq_epoch)
    );

    // Lane 0 races for bit value 1, lane 1 for bit value 0
    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
        ro_select_tree #(.N_OSC(N_OSC), .SEL_W(SEL_W)) u_tree (
            .osc_bank (osc_bank),
            .sel      (lane_sel[ln]),
            .clk_out  (lane_clk[ln])
        );
        race_lane #(.CNT_W(CNT_W)) u_lane (
            .lane_clk   (lane_clk[ln]),
            .rst_n      (rst_n),
            .epoch      (seq_epoch),
            .ovf_toggle (lane_ovf[ln])
        );
    end

    race_judge #(.RESP_W(RESP_W), .TIE_BIT(TIE_BIT)) u_judge (
        .inner_clk (inner_clk),
        .rst_n     (rst_n),
        .epoch     (seq_epoch),
        .ovf_a     (lane_ovf[0]),
        .ovf_b     (lane_ovf[1]),
        .response  (response),
        .done      (done)
    );

endmodule

// File: rtl/ro_race_puf_chk.sv
`timescale 1ns/1ps
// Property checker for ro_race_puf, attached by bind below.
// Tracks epoch flips with its own counter to know where a sequence begins.
module ro_race_puf_chk #(
    parameter int unsigned RESP_W = 8,
    parameter int unsigned SEL_W  = 4
) (
    input logic              inner_clk,
    input logic              outer_clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic [RESP_W-1:0] response,
    input logic              epoch,
    input logic [SEL_W-1:0]  sel_a,
    input logic [SEL_W-1:0]  sel_b
);
    localparam int unsigned F_W = $clog2(RESP_W + 2);

    logic           ep_q;
    logic [F_W-1:0] flips_q;
    logic           flip;

    assign flip = epoch != ep_q;

    // Count epoch flips within the current sequence
    always_ff @(posedge outer_clk) begin
        if (!rst_n) begin
            ep_q    <= 1'b0;
            flips_q <= '0;
        end else begin
            ep_q <= epoch;
            if (flip) flips_q <= (flips_q == F_W'(RESP_W)) ? '0 : flips_q + 1'b1;
        end
    end

    // R7: done lasts one capture cycle
    a_r7_done_single: assert property (@(posedge inner_clk) disable iff (!rst_n)
        done |=> !done);

    // R7: response only changes together with done
    a_r7_resp_hold: assert property (@(posedge inner_clk) disable iff (!rst_n)
        !$stable(response) |-> done);

    // R4: selections reload only on an edge that opens a race
    a_r4_sel_with_epoch: assert property (@(posedge outer_clk) disable iff (!rst_n)
        (!$stable(sel_a) || !$stable(sel_b)) |-> !$stable(epoch));

    // R8: a sequence opens only on an accepted start
    a_r8_open_needs_start: assert property (@(posedge outer_clk) disable iff (!rst_n)
        (flip && flips_q == '0) |-> $past(start));

endmodule

bind ro_race_puf ro_race_puf_chk #(.RESP_W(RESP_W), .SEL_W($clog2(N_OSC))) u_chk (
    .inner_clk (inner_clk),
    .outer_clk (outer_clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .response  (response),
    .epoch     (seq_epoch),
    .sel_a     (sel_a),
    .sel_b     (sel_b)
);

// File: tb/ro_race_puf_test.sv
`timescale 1ns/1ps
// Bench for ro_race_puf: behavioural oscillators spread within ±5% of 40 ns,
// a vector table walked by one loop, then directed corner tests.
module ro_race_puf_test;
    localparam int unsigned N_OSC  = 16;
    localparam int unsigned RESP_W = 8;
    localparam int unsigned CH_W   = 8;
    localparam bit          TIE    = 1'b1;
    localparam int          LIMIT  = 20000;

    logic [N_OSC-1:0]  osc_bank;
    logic              outer_clk = 1'b0;
    logic              inner_clk = 1'b0;
    logic              rst_n     = 1'b0;
    logic [CH_W-1:0]   challenge = '0;
    logic              start     = 1'b0;
    logic [RESP_W-1:0] response;
    logic              done;

    int n_vec = 0;
    int n_bad = 0;
    int outer_edges = 0;
    realtime outer_half = 6000.0;

    ro_race_puf #(.N_OSC(N_OSC), .CNT_W(8), .RESP_W(RESP_W), .TIE_BIT(TIE)) uut (
        .osc_bank (osc_bank), .outer_clk (outer_clk), .inner_clk (inner_clk),
        .rst_n (rst_n), .challenge (challenge), .start (start),
        .response (response), .done (done)
    );

    // Speed rank of oscillator i: lower rank means shorter period
    function automatic int rank_of(input int i);
        return (i * 7 + 3) % 16;
    endfunction

    function automatic real period_of(input int i);
        return 38.0 + rank_of(i) * 0.2667;
    endfunction

    for (genvar i = 0; i < N_OSC; i++) begin : g_osc
        logic o = 1'b0;
        initial begin
            realtime h;
            h = period_of(i) / 2.0;
            forever #(h) o = ~o;
        end
        assign osc_bank[i] = o;
    end

    always #10 inner_clk = ~inner_clk;                 // 50 MHz capture clock
    initial forever #(outer_half) outer_clk = ~outer_clk;
    always @(posedge outer_clk) outer_edges++;

    // Expected response from the requirements (R1, R4, R5)
    function automatic logic [RESP_W-1:0] model(input logic [CH_W-1:0] ch);
        logic [RESP_W-1:0] r;
        for (int k = 0; k < RESP_W; k++) begin
            logic [CH_W-1:0] c;
            int a, b;
            c = (ch << k) | (ch >> (CH_W - k));
            a = int'(c[3:0]);
            b = int'(c[7:4]);
            if (a == b) r[k] = TIE;
            else        r[k] = (rank_of(a) < rank_of(b)) ? 1'b1 : 1'b0;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Issue one start and wait for done; report response and load edges used
    task automatic run_seq(input logic [CH_W-1:0] ch, input int poke_at,
                           input logic [CH_W-1:0] poke_ch,
                           output logic [RESP_W-1:0] resp, output int edges, output bit seen);
        int e0;
        @(negedge outer_clk);
        challenge = ch;
        start = 1'b1;
        e0 = outer_edges;
        @(negedge outer_clk);
        start = 1'b0;
        if (poke_at > 0) begin
            repeat (poke_at) @(negedge outer_clk);
            challenge = poke_ch;
            start = 1'b1;
            @(negedge outer_clk);
            start = 1'b0;
        end
        seen = 1'b0;
        resp = '0;
        for (int c = 0; c < LIMIT && !seen; c++) begin
            @(negedge inner_clk);
            if (done) begin
                seen = 1'b1;
                resp = response;
            end
        end
        edges = outer_edges - e0;
    endtask

    localparam logic [CH_W-1:0] VEC [8] = '{8'h10, 8'hF0, 8'h5A, 8'h3C,
                                            8'h81, 8'hB4, 8'hE7, 8'h29};

    initial begin
        repeat (190000) @(posedge inner_clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [RESP_W-1:0] got;
        int edges;
        bit seen;

        #13000;
        @(negedge inner_clk);
        check(response == '0, "R9 response after reset", int'(response), 0);
        check(done == 1'b0, "R9 done after reset", int'(done), 0);
        rst_n = 1'b1;

        // Table walk: R1/R2/R4 bit values, R7 sequence length
        for (int v = 0; v < 8; v++) begin
            run_seq(VEC[v], 0, '0, got, edges, seen);
            check(seen, "R7 done seen", int'(seen), 1);
            check(got == model(VEC[v]), "R1 R2 R4 response", int'(got), int'(model(VEC[v])));
            check(edges == RESP_W + 1, "R7 load edges per sequence", edges, RESP_W + 1);
            @(negedge inner_clk);
            check(done == 1'b0, "R7 done single cycle", int'(done), 0);
            check(response == got, "R7 response held", int'(response), int'(got));
        end

        // R5: equal fields in every rotation give ties
        run_seq(8'h33, 0, '0, got, edges, seen);
        check(seen && got == {RESP_W{TIE}}, "R5 tie bits", int'(got), int'({RESP_W{TIE}}));

        // R8: second start mid-sequence is ignored
        run_seq(8'h5A, 3, 8'h0F, got, edges, seen);
        check(seen && got == model(8'h5A), "R8 start ignored response", int'(got), int'(model(8'h5A)));
        check(edges == RESP_W + 1, "R8 sequence length kept", edges, RESP_W + 1);

        // R3: long window, counters wrap more than once, first wrap decides
        outer_half = 18000.0;
        run_seq(8'hB4, 0, '0, got, edges, seen);
        check(seen && got == model(8'hB4), "R3 first wrap decides", int'(got), int'(model(8'hB4)));

        // R6: window too short for any wrap
        outer_half = 1000.0;
        run_seq(8'h10, 0, '0, got, edges, seen);
        check(seen && got == {RESP_W{TIE}}, "R6 no wrap gives tie bit", int'(got), int'({RESP_W{TIE}}));

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule